// File: doc/BRIEF.md
# Asynchronous Bus Transfer Sequencer

This block carries out a single 16-bit read or write on a microprocessor bus whose slaves answer with an active-low transfer acknowledge. The clock runs at half-cycle rate, so every phase length below is a count of clock cycles. A requester supplies a 32-bit byte address, a direction, two byte-lane selects, a three-bit processor status code and, for writes, a data word. The sequencer then drives the address strobe, the two data strobes, the read/write line, the function-code lines and the word address.

Each transfer has four parts. A fixed address phase comes first. Wait states follow, added in pairs for as long as the synchronised acknowledge is still absent. A fixed data phase comes next, during which a read samples the bus. The transfer closes with a quiet cycle in which every strobe is released and a done pulse is raised. While a transfer is in progress the block shows busy, and it neither accepts nor remembers a new request.

Top module: `abus_xfer_ctrl`

## Requirements
- R1: When `req_i` is high in a cycle where `busy_o` is low, the request is accepted at that clock edge. `as_n_o` goes low in the very next cycle and stays low for the 5-cycle address phase, any wait cycles and the data phase.
- R2: The data phase lasts exactly 3 cycles and ends on the last cycle in which `as_n_o` is low. Both data strobes stay high during the address phase and the wait cycles.
- R3: `dtack_n_i` passes through a two-flop synchroniser. If it is driven low in cycle k after acceptance (cycle 0 is the first cycle of the address phase), the number of wait cycles is 2·w, where w is the smallest integer ≥ 0 with 4 + 2·w ≥ k + 2.
- R4: Throughout the transfer, `bus_addr_o` carries bits 23 down to 1 of `req_addr_i` as captured at acceptance. Bit 0 and bits 31..24 have no effect on any output.
- R5: `rw_o` is high during a read transfer (`req_rd_i`=1) and low from the address phase through the data phase of a write. It is high when idle.
- R6: `fc_o` carries the status code captured at acceptance for the whole transfer. Bit 0 means data access, bit 1 means program access and bit 2 means supervisor. The value 3'b111 passes through unchanged as an interrupt-acknowledge code.
- R7: `req_be_i[1]` selects the upper lane (`uds_n_o`) and `req_be_i[0]` selects the lower lane (`lds_n_o`). The values 2'b11 and 2'b00 both give a full-word transfer with both strobes low. A single set bit gives a byte transfer with only that strobe low.
- R8: On a read, `rdata_o` takes the value of `bus_din_i` from the last data-phase cycle and shows it from the done cycle onward. A write leaves `rdata_o` unchanged. During a write, `bus_dout_o` carries the captured `req_wdata_i`.
- R9: After the data phase there is exactly one cycle in which all three strobes are high, `busy_o` is high and `done_o` is high. In the following cycle `busy_o` and `done_o` are both low.
- R10: A request raised while `busy_o` is high is ignored and is not queued. The captured address does not change, and no further transfer starts once the current one ends unless `req_i` is high again while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request |
| req_addr_i | input | 32 | Byte address |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_be_i | input | 2 | Lane selects: [1] upper, [0] lower |
| req_fc_i | input | 3 | Status code: [0] data, [1] program, [2] supervisor |
| req_wdata_i | input | 16 | Write data |
| dtack_n_i | input | 1 | Asynchronous active-low acknowledge from the slave |
| bus_din_i | input | 16 | Data bus input |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| as_n_o | output | 1 | Address strobe, active low |
| uds_n_o | output | 1 | Upper data strobe, active low |
| lds_n_o | output | 1 | Lower data strobe, active low |
| rw_o | output | 1 | Read/write line |
| fc_o | output | 3 | Function-code lines |
| bus_addr_o | output | 23 | Word address, bits 23..1 |
| bus_dout_o | output | 16 | Write data to the bus |
| rdata_o | output | 16 | Registered read data |

## Verification
All strobe outputs decode from the registered phase, so they change in the cycle that follows the accepting edge. The bench numbers cycles from that point and, from the acknowledge cycle k, computes when each output is due: the address strobe falls in cycle 0, the data strobes fall in cycle 5+2w, and done, the released strobes and the new read data appear together in cycle 8+2w. The bench samples every output on the falling clock edge of each numbered cycle and drives the acknowledge on that same falling edge. Each result is therefore compared in exactly the cycle the formula predicts, across acknowledge delays that cover zero, one and several wait pairs.

// File: rtl/abus_pkg.sv
package abus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_WAIT = 3'd2,
    PH_DATA = 3'd3,
    PH_GAP  = 3'd4
  } phase_e;

  // Active-high lane enables {upper, lower}; an empty select means a full word.
  function automatic logic [1:0] lane_enables(logic [1:0] be);
    return (be == 2'b00) ? 2'b11 : be;
  endfunction

  // Keep only the word-address bits that reach the bus.
  function automatic logic [22:0] word_addr(logic [31:0] byte_addr);
    return byte_addr[23:1];
  endfunction

endpackage

// File: rtl/abus_ack_sync.sv
module abus_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_i,
  output logic ack_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= ack_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= {sr_q[STAGES-2:0], ack_n_i};
      end
    end
  endgenerate

  assign ack_o = ~sr_q[STAGES-1];
endmodule

// File: rtl/abus_phase_seq.sv
module abus_phase_seq
  import abus_pkg::*;
#(
  parameter int ADDR_HC = 5,
  parameter int WAIT_HC = 2,
  parameter int DATA_HC = 3,
  parameter int GAP_HC  = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   ack_i,
  output phase_e phase_o,
  output logic   sample_o,
  output logic   done_o
);
  localparam int MAXHC = (ADDR_HC > DATA_HC) ? ADDR_HC : DATA_HC;
  localparam int CW    = $clog2(MAXHC + WAIT_HC + GAP_HC) + 1;

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  function automatic int span(phase_e p);
    case (p)
      PH_ADDR: return ADDR_HC;
      PH_WAIT: return WAIT_HC;
      PH_DATA: return DATA_HC;
      PH_GAP:  return GAP_HC;
      default: return 1;
    endcase
  endfunction

  assign last = (cnt_q == CW'(span(phase_q) - 1));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + 1'b1;
    case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start_i) phase_d = PH_ADDR;
      end
      PH_ADDR, PH_WAIT: begin
        if (last) begin
          cnt_d   = '0;
          phase_d = ack_i ? PH_DATA : PH_WAIT;
        end
      end
      PH_DATA: begin
        if (last) begin
          cnt_d   = '0;
          phase_d = PH_GAP;
        end
      end
      PH_GAP: begin
        if (last) begin
          cnt_d   = '0;
          phase_d = PH_IDLE;
        end
      end
      default: begin
        cnt_d   = '0;
        phase_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o  = phase_q;
  assign sample_o = (phase_q == PH_DATA) && last;
  assign done_o   = (phase_q == PH_GAP) && last;

  // The data phase is entered only after the synchronised acknowledge was seen.
  assert_data_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && $past(phase_q) != PH_DATA) |-> $past(ack_i));

  // Wait cycles only follow the address phase or another wait pair.
  assert_wait_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) |-> ($past(phase_q) == PH_ADDR || $past(phase_q) == PH_WAIT));

  // A new transfer starts only from idle.
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR && $past(phase_q) != PH_ADDR) |-> $past(phase_q) == PH_IDLE);
endmodule

// File: rtl/abus_bus_drv.sv
module abus_bus_drv
  import abus_pkg::*;
#(
  parameter int IN_AW   = 32,
  parameter int ADDR_HI = 23,
  parameter int DW      = 16,
  parameter int FCW     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  phase_e             phase_i,
  input  logic               sample_i,
  input  logic [IN_AW-1:0]   addr_i,
  input  logic               rd_i,
  input  logic [1:0]         be_i,
  input  logic [FCW-1:0]     fc_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW-1:0]      din_i,
  output logic               as_n_o,
  output logic               uds_n_o,
  output logic               lds_n_o,
  output logic               rw_o,
  output logic [FCW-1:0]     fc_o,
  output logic [ADDR_HI:1]   addr_o,
  output logic [DW-1:0]      dout_o,
  output logic [DW-1:0]      rdata_o
);
  logic [ADDR_HI:1] addr_q;
  logic             rd_q;
  logic [1:0]       lanes_q;
  logic [FCW-1:0]   fc_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic             in_xfer, in_data;
  logic             unused_addr_bits;

  assign unused_addr_bits = ^{addr_i[0], addr_i[IN_AW-1:ADDR_HI+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_q    <= 1'b1;
      lanes_q <= 2'b11;
      fc_q    <= '0;
      wdata_q <= '0;
    end else if (start_i) begin
      addr_q  <= addr_i[ADDR_HI:1];
      rd_q    <= rd_i;
      lanes_q <= lane_enables(be_i);
      fc_q    <= fc_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdata_q <= '0;
    else if (sample_i && rd_q) rdata_q <= din_i;
  end

  assign in_xfer = (phase_i == PH_ADDR) || (phase_i == PH_WAIT) || (phase_i == PH_DATA);
  assign in_data = (phase_i == PH_DATA);

  assign as_n_o  = ~in_xfer;
  assign uds_n_o = ~(in_data && lanes_q[1]);
  assign lds_n_o = ~(in_data && lanes_q[0]);
  assign rw_o    = in_xfer ? rd_q : 1'b1;
  assign fc_o    = fc_q;
  assign addr_o  = addr_q;
  assign dout_o  = wdata_q;
  assign rdata_o = rdata_q;

  // Every data phase drives at least one lane.
  assert_lane_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> $countones({~uds_n_o, ~lds_n_o}) >= 1);

  // Captured request fields hold while a transfer runs.
  assert_fields_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !start_i) |=> (phase_i == PH_IDLE) || (phase_i == PH_GAP) || $stable(addr_q));
endmodule

// File: rtl/abus_xfer_ctrl.sv
module abus_xfer_ctrl
  import abus_pkg::*;
#(
  parameter int IN_AW       = 32,
  parameter int ADDR_HI     = 23,
  parameter int DW          = 16,
  parameter int FCW         = 3,
  parameter int ADDR_HC     = 5,
  parameter int WAIT_HC     = 2,
  parameter int DATA_HC     = 3,
  parameter int GAP_HC      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [IN_AW-1:0] req_addr_i,
  input  logic             req_rd_i,
  input  logic [1:0]       req_be_i,
  input  logic [FCW-1:0]   req_fc_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic             dtack_n_i,
  input  logic [DW-1:0]    bus_din_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             as_n_o,
  output logic             uds_n_o,
  output logic             lds_n_o,
  output logic             rw_o,
  output logic [FCW-1:0]   fc_o,
  output logic [ADDR_HI:1] bus_addr_o,
  output logic [DW-1:0]    bus_dout_o,
  output logic [DW-1:0]    rdata_o
);
  phase_e phase;
  logic   ack_seen, start, sample;

  assign busy_o = (phase != PH_IDLE);
  assign start  = req_i && !busy_o;

  abus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ack_n_i(dtack_n_i), .ack_o(ack_seen)
  );

  abus_phase_seq #(
    .ADDR_HC(ADDR_HC), .WAIT_HC(WAIT_HC), .DATA_HC(DATA_HC), .GAP_HC(GAP_HC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ack_i(ack_seen),
    .phase_o(phase), .sample_o(sample), .done_o(done_o)
  );

  abus_bus_drv #(
    .IN_AW(IN_AW), .ADDR_HI(ADDR_HI), .DW(DW), .FCW(FCW)
  ) u_drv (
    .clk(clk), .rst_n(rst_n), .start_i(start), .phase_i(phase), .sample_i(sample),
    .addr_i(req_addr_i), .rd_i(req_rd_i), .be_i(req_be_i), .fc_i(req_fc_i),
    .wdata_i(req_wdata_i), .din_i(bus_din_i),
    .as_n_o(as_n_o), .uds_n_o(uds_n_o), .lds_n_o(lds_n_o), .rw_o(rw_o),
    .fc_o(fc_o), .addr_o(bus_addr_o), .dout_o(bus_dout_o), .rdata_o(rdata_o)
  );

  assert_accept_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !as_n_o);

  assert_ds_inside_as_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!uds_n_o || !lds_n_o) |-> !as_n_o);

  assert_gap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (as_n_o && uds_n_o && lds_n_o && busy_o));

  assert_rdata_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_o) |-> done_o);

  assert_write_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    as_n_o |-> rw_o);
endmodule

// File: tb/sim_abus_xfer_ctrl.sv
module sim_abus_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_rd_i = 1'b1;
  logic [1:0]  req_be_i = 2'b11;
  logic [2:0]  req_fc_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        dtack_n_i = 1'b1;
  logic [15:0] bus_din_i = '0;
  logic        busy_o, done_o, as_n_o, uds_n_o, lds_n_o, rw_o;
  logic [2:0]  fc_o;
  logic [23:1] bus_addr_o;
  logic [15:0] bus_dout_o, rdata_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] last_rd = '0;

  always #10 clk = ~clk;

  abus_xfer_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_rd_i(req_rd_i), .req_be_i(req_be_i), .req_fc_i(req_fc_i),
    .req_wdata_i(req_wdata_i), .dtack_n_i(dtack_n_i), .bus_din_i(bus_din_i),
    .busy_o(busy_o), .done_o(done_o), .as_n_o(as_n_o), .uds_n_o(uds_n_o),
    .lds_n_o(lds_n_o), .rw_o(rw_o), .fc_o(fc_o), .bus_addr_o(bus_addr_o),
    .bus_dout_o(bus_dout_o), .rdata_o(rdata_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One transfer; dtack driven low in cycle k after acceptance.
  task automatic run_xfer(input logic [31:0] addr, input bit rd, input logic [1:0] be,
                          input logic [2:0] fc, input logic [15:0] wd,
                          input logic [15:0] rv, input int k);
    int w = 0;
    int as_total, ds_start, bad_as, bad_ds, bad_rw, bad_addr, bad_done;
    logic [1:0] lanes;
    while (4 + 2 * w < k + 2) w++;
    as_total = 5 + 2 * w + 3;
    ds_start = 5 + 2 * w;
    lanes = (be == 2'b00) ? 2'b11 : be;
    bad_as = 0; bad_ds = 0; bad_rw = 0; bad_addr = 0; bad_done = 0;
    @(negedge clk);
    req_i = 1'b1; req_addr_i = addr; req_rd_i = rd; req_be_i = be;
    req_fc_i = fc; req_wdata_i = wd; bus_din_i = rv;
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    for (int c = 0; c <= as_total; c++) begin
      if (c > 0) @(negedge clk);
      if (c == k) dtack_n_i = 1'b0;
      if (c < as_total) begin
        if (as_n_o !== 1'b0) bad_as++;
        if (c >= ds_start) begin
          if ({uds_n_o, lds_n_o} !== ~lanes) bad_ds++;
        end else if ({uds_n_o, lds_n_o} !== 2'b11) bad_ds++;
        if (rw_o !== rd) bad_rw++;
        if (bus_addr_o !== addr[23:1] || fc_o !== fc) bad_addr++;
        if (done_o !== 1'b0 || busy_o !== 1'b1) bad_done++;
        if (c == ds_start && !rd)
          chk(bus_dout_o == wd, "R8 write data", bus_dout_o, wd);
      end
    end
    chk(bad_as == 0, "R1 address strobe window", bad_as, 0);
    chk(bad_ds == 0, "R2/R3/R7 data strobe timing", bad_ds, 0);
    chk(bad_rw == 0, "R5 rw line", bad_rw, 0);
    chk(bad_addr == 0, "R4/R6 addr and fc", bad_addr, 0);
    // cycle as_total: quiet gap with done (R9)
    chk(done_o && busy_o && as_n_o && uds_n_o && lds_n_o, "R9 gap and done",
        {done_o, busy_o, as_n_o, uds_n_o, lds_n_o}, 5'b11111);
    chk(bad_done == 0, "R9 no early done", bad_done, 0);
    if (rd) last_rd = rv;
    chk(rdata_o == last_rd, "R8 read data", rdata_o, last_rd);
    dtack_n_i = 1'b1;
    @(negedge clk);
    chk(!done_o && !busy_o, "R9 back to idle", {done_o, busy_o}, 0);
  endtask

  task automatic t_reset();
    chk(as_n_o && uds_n_o && lds_n_o && rw_o && !busy_o && !done_o, "R1 reset state",
        {as_n_o, uds_n_o, lds_n_o, rw_o, busy_o, done_o}, 6'b111100);
    chk(rdata_o == 16'h0, "R8 reset rdata", rdata_o, 0);
  endtask

  // Request during busy is ignored and not queued.
  task automatic t_busy();
    int started = 0;
    @(negedge clk);
    req_i = 1'b1; req_addr_i = 32'h0000_0100; req_rd_i = 1'b1; req_be_i = 2'b11;
    req_fc_i = 3'b101;
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0; dtack_n_i = 1'b0;
    @(negedge clk);
    req_i = 1'b1; req_addr_i = 32'h0000_0F00; req_fc_i = 3'b010;
    @(negedge clk);
    chk(busy_o == 1'b1, "R10 busy during transfer", busy_o, 1);
    req_i = 1'b0;
    chk(bus_addr_o == 23'h80 && fc_o == 3'b101, "R10 held request ignored",
        bus_addr_o, 23'h80);
    while (!done_o) @(negedge clk);
    dtack_n_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!as_n_o || busy_o) started++;
    end
    chk(started == 0, "R10 no queued transfer", started, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3: ack before the decision point, no waits
    run_xfer(32'hFF12_3457, 1'b1, 2'b11, 3'b001, 16'h0, 16'hA5C3, 0);
    // R3: one wait pair
    run_xfer(32'h0000_2000, 1'b1, 2'b10, 3'b010, 16'h0, 16'h1234, 3);
    // R3: three wait pairs, write, lower lane
    run_xfer(32'h8000_0003, 1'b0, 2'b01, 3'b101, 16'hBEEF, 16'hFFFF, 7);
    // R6: interrupt-ack code, empty select is a full word (R7)
    run_xfer(32'h00FF_FFFE, 1'b1, 2'b00, 3'b111, 16'h0, 16'h0F0F, 2);
    // R5: word write, boundary at k=4
    run_xfer(32'h0055_AA00, 1'b0, 2'b11, 3'b110, 16'h5A5A, 16'h0000, 4);
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule